// File: doc/BRIEF.md
# SD Card SPI Byte Master

This block lets a small processor exchange bytes with an SD card in SPI mode through three word-wide registers, with no bit banging. Writing the data register loads a transmit byte and starts one 8-bit full-duplex exchange. The processor then polls a status flag until the exchange is over, and reads the byte the card returned from the same data register.

A control register sets the card select line directly. Its second bit picks the serial clock rate. The slow rate is for card initialisation and the fast rate is for bulk transfer. The rate is latched when an exchange starts, so a control write in the middle of a byte does not disturb that byte.

The serial clock idles low and the bus runs in mode 0: the outgoing bit changes after each falling edge, the incoming bit is captured on each rising edge, and the most significant bit goes first. Between exchanges the outgoing line rests high.

Top module: `sd_spi_master`

## Requirements
- R1: After reset, the status word reads 0, `spiCsN` is 1, `spiMosi` is 1, `spiClk` is 0, and the divider is 0x80, so the first exchange lasts 2048 cycles.
- R2: A write to address 0 while idle starts an exchange. Only bits 7:0 of the written word are transmitted. Busy (status bit 0) is already 1 in the cycle after the write edge.
- R3: The transmitted byte goes out most significant bit first. Each bit is stable on `spiMosi` at the rising edge of `spiClk` that follows it.
- R4: A read of address 0 returns, in bits 7:0, the eight `spiMiso` bits captured on the rising edges of the last finished exchange, first bit in bit 7. Bits 31:8 read 0.
- R5: Busy stays 1 for the whole exchange. It returns to 0 exactly 16 times the divider value in cycles after the starting write edge, at the moment `spiClk` goes low after the eighth rising edge.
- R6: A write to address 0 while busy is 1 is ignored. The byte on the line and the length of the exchange are unchanged.
- R7: A write to address 2 sets `spiCsN` to data bit 0 one cycle after the write edge. `spiCsN` changes at no other time.
- R8: In a write to address 2, data bit 1 = 1 selects divider 0x80 and bit 1 = 0 selects divider 0x04. A half period of `spiClk` lasts the divider value in system cycles.
- R9: A divider chosen during an exchange applies only from the next exchange.
- R10: While busy is 0, `spiClk` is 0 and `spiMosi` is 1.
- R11: The status word at address 1 holds busy in bit 0 and zeros above it. Reads of addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 2 | Register select: 0 data, 1 status, 2 control |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 32 | Write data word |
| rdData | output | 32 | Read data for `regAddr` (combinational) |
| spiClk | output | 1 | Serial clock to the card |
| spiMosi | output | 1 | Serial data to the card (command pin) |
| spiMiso | input | 1 | Serial data from the card (data pin) |
| spiCsN | output | 1 | Card select, active low (DAT3 pin) |

## Verification
The assertions assume that `wrEn` is a single-cycle pulse with a legal address, and that `spiMiso` is synchronous to `clk` and moves only after falling edges of `spiClk`. The bench card model changes its output bit only in response to a falling serial clock edge. Stimulus is driven on the falling system clock edge, and each write lasts exactly one cycle. The bench waits for busy to clear before it reads a received byte, except in the case where it deliberately writes the data register during an exchange.

// File: rtl/sd_spi_pkg.sv
package sd_spi_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_DATA   = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  // strobes from the control unit to the shift datapath
  typedef struct packed {
    logic active;     // exchange in progress
    logic load;       // capture new transmit byte
    logic sample;     // rising serial edge: take one input bit
    logic lastSample; // the eighth rising edge
    logic shift;      // falling serial edge: present next output bit
  } spiStrobes_t;
endpackage

// File: rtl/sd_spi_ctrl.sv
module sd_spi_ctrl
  import sd_spi_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int SLOW_DIV = 128,
  parameter int FAST_DIV = 4,
  parameter int BYTE_W   = 8,
  parameter int WORD_W   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  wrEn,
  input  logic [WORD_W-1:0]     wrData,
  output spiStrobes_t           strobes,
  output logic                  busy,
  output logic                  sclk,
  output logic                  csN
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [DIV_W-1:0] SLOW_VAL = DIV_W'(SLOW_DIV);
  localparam logic [DIV_W-1:0] FAST_VAL = DIV_W'(FAST_DIV);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic             slowSel;
  logic [DIV_W-1:0] activeDiv;
  logic [DIV_W-1:0] halfCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             startXfer, ctrlWr, halfTick;

  assign startXfer = wrEn && (regAddr == ADDR_DATA) && !busy;
  assign ctrlWr    = wrEn && (regAddr == ADDR_CTRL);
  assign halfTick  = busy && (halfCnt == activeDiv - DIV_W'(1));

  always_comb begin
    strobes.active     = busy;
    strobes.load       = startXfer;
    strobes.sample     = halfTick && !sclk;
    strobes.lastSample = halfTick && !sclk && (bitCnt == LAST_BIT);
    strobes.shift      = halfTick && sclk && (bitCnt != LAST_BIT);
  end

  // software control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN     <= 1'b1;
      slowSel <= 1'b1;
    end else if (ctrlWr) begin
      csN     <= wrData[0];
      slowSel <= wrData[1];
    end
  end

  // sequencer: clock divider, serial clock and bit count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      sclk      <= 1'b0;
      halfCnt   <= '0;
      bitCnt    <= '0;
      activeDiv <= SLOW_VAL;
    end else if (startXfer) begin
      busy      <= 1'b1;
      sclk      <= 1'b0;
      halfCnt   <= '0;
      bitCnt    <= '0;
      activeDiv <= slowSel ? SLOW_VAL : FAST_VAL;
    end else if (busy) begin
      if (halfTick) begin
        halfCnt <= '0;
        sclk    <= ~sclk;
        if (sclk) begin
          if (bitCnt == LAST_BIT) begin
            busy   <= 1'b0;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
      end else begin
        halfCnt <= halfCnt + DIV_W'(1);
      end
    end
  end

  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startXfer));
  assert_div_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(activeDiv));
  assert_cs_write_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrlWr) |-> $stable(csN));
  assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);
  assert_end_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $fell(sclk));
endmodule

// File: rtl/sd_spi_datapath.sv
module sd_spi_datapath
  import sd_spi_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobes_t       strobes,
  input  logic [WORD_W-1:0] wrData,
  input  logic              miso,
  output logic              mosi,
  output logic [BYTE_W-1:0] rxByte
);
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (strobes.load) begin
      txShift <= wrData[BYTE_W-1:0];
    end else if (strobes.shift) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxByte  <= '0;
    end else if (strobes.sample) begin
      rxShift <= {rxShift[BYTE_W-2:0], miso};
      if (strobes.lastSample) rxByte <= {rxShift[BYTE_W-2:0], miso};
    end
  end

  assign mosi = strobes.active ? txShift[BYTE_W-1] : 1'b1;

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.lastSample) |-> $stable(rxByte));
  assert_tx_ignore_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.active) && !$past(strobes.shift)) |-> $stable(txShift));
endmodule

// File: rtl/sd_spi_master.sv
module sd_spi_master
  import sd_spi_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int SLOW_DIV = 128,
  parameter int FAST_DIV = 4,
  parameter int BYTE_W   = 8,
  parameter int WORD_W   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  wrEn,
  input  logic [WORD_W-1:0]     wrData,
  output logic [WORD_W-1:0]     rdData,
  output logic                  spiClk,
  output logic                  spiMosi,
  input  logic                  spiMiso,
  output logic                  spiCsN
);
  spiStrobes_t       strobes;
  logic              busy;
  logic [BYTE_W-1:0] rxByte;

  sd_spi_ctrl #(
    .DIV_W(DIV_W), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV),
    .BYTE_W(BYTE_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .strobes(strobes), .busy(busy), .sclk(spiClk), .csN(spiCsN)
  );

  sd_spi_datapath #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .miso(spiMiso), .mosi(spiMosi), .rxByte(rxByte)
  );

  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_DATA:   rdData[BYTE_W-1:0] = rxByte;
      ADDR_STATUS: rdData[0] = busy;
      default:     rdData = '0;
    endcase
  end

  assert_mosi_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiMosi);
endmodule

// File: tb/sd_spi_master_tb.sv
module sd_spi_master_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        spiClk, spiMosi, spiCsN;
  logic        spiMiso = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  int startCycle = 0;
  bit done = 1'b0;

  logic [7:0] expTx[$];
  logic [7:0] reply = 8'h00;
  logic [7:0] capByte = 8'h00;
  int         capBits = 0;

  sd_spi_master u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .spiClk(spiClk), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .spiCsN(spiCsN)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // card model: next bit presented after each falling serial edge
  always @(negedge spiClk) begin
    reply   = {reply[6:0], 1'b0};
    spiMiso = reply[7];
  end

  // monitor: gather outgoing bits on rising edges, compare with scoreboard
  always @(posedge spiClk) begin
    capByte = {capByte[6:0], spiMosi};
    capBits++;
    if (capBits == 8) begin
      capBits = 0;
      if (expTx.size() == 0) check(1'b0, "R3 unexpected byte", capByte, 0);
      else begin
        logic [7:0] e;
        e = expTx.pop_front();
        check(capByte == e, "R3 mosi byte", capByte, e);
      end
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = rdData;
  endtask

  // driver: load the card reply, push expected byte, start exchange
  task automatic startXfer(input logic [31:0] word, input logic [7:0] cardByte);
    logic [31:0] st;
    reply = cardByte;
    spiMiso = cardByte[7];
    expTx.push_back(word[7:0]);
    regWrite(2'd0, word);
    startCycle = cycleCnt;
    regRead(2'd1, st);
    check(st == 32'd1, "R2 busy after start", st, 1);
  endtask

  task automatic waitIdle(output int elapsed);
    logic [31:0] st;
    regRead(2'd1, st);
    while (st[0]) begin
      check(st == 32'd1, "R5 R11 status word while busy", st, 1);
      @(negedge clk);
      regRead(2'd1, st);
    end
    elapsed = cycleCnt - startCycle;
    check(spiClk == 1'b0 && spiMosi == 1'b1, "R10 idle lines",
          {spiClk, spiMosi}, 2'b01);
  endtask

  task automatic fullXfer(input logic [31:0] word, input logic [7:0] cardByte,
                          input int div, input string tag);
    int el;
    logic [31:0] d;
    startXfer(word, cardByte);
    waitIdle(el);
    check(el == 16 * div, tag, el, 16 * div);
    regRead(2'd0, d);
    check(d == {24'd0, cardByte}, "R4 received byte", d, {24'd0, cardByte});
  endtask

  initial begin
    logic [31:0] d;
    int el;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regRead(2'd1, d);
    check(d == 0, "R1 status after reset", d, 0);
    check(spiCsN == 1'b1, "R1 cs after reset", spiCsN, 1);
    check(spiMosi == 1'b1 && spiClk == 1'b0, "R1 lines after reset",
          {spiClk, spiMosi}, 2'b01);

    // default slow divider, upper word bits ignored
    fullXfer(32'hDEAD_BE5A, 8'hC3, 128, "R1 R8 slow default length");

    // chip select low, fast rate
    regWrite(2'd2, 32'h0);
    check(spiCsN == 1'b0, "R7 cs low", spiCsN, 0);
    fullXfer(32'h0000_0081, 8'h5A, 4, "R8 fast length");
    fullXfer(32'hFFFF_FF00, 8'hFF, 4, "R2 low byte only length");
    fullXfer(32'h0000_0001, 8'h01, 4, "R5 length");

    // ignored write while busy
    startXfer(32'h0000_00A5, 8'h96);
    repeat (5) @(negedge clk);
    regWrite(2'd0, 32'h0000_003C);
    waitIdle(el);
    check(el == 64, "R6 length unchanged", el, 64);
    regRead(2'd0, d);
    check(d == 32'h96, "R6 R4 rx after ignored write", d, 32'h96);

    // divider change mid exchange; cs stays low (bit0 = 0)
    startXfer(32'h0000_0033, 8'hA0);
    repeat (3) @(negedge clk);
    regWrite(2'd2, 32'h2);
    check(spiCsN == 1'b0, "R7 cs follows bit0", spiCsN, 0);
    waitIdle(el);
    check(el == 64, "R9 old divider kept", el, 64);
    fullXfer(32'h0000_00E7, 8'h18, 128, "R9 new divider next exchange");

    // register map reads
    regRead(2'd2, d);
    check(d == 0, "R11 control reads zero", d, 0);
    regRead(2'd3, d);
    check(d == 0, "R11 unused reads zero", d, 0);

    // deselect
    regWrite(2'd2, 32'h1);
    check(spiCsN == 1'b1, "R7 cs high", spiCsN, 1);
    check(expTx.size() == 0, "R3 all bytes seen", expTx.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule